// File: doc/BRIEF.md
# Rate-Batched Maximal Matching Crossbar Scheduler

This block schedules the crossbar of an N-by-N switch that queues cells at both its inputs and its outputs, and it gives each input-output pair a reserved bandwidth. Software sets a reservation for each pair as a number of cells per frame. It writes these reservations while the block is disabled. Each arriving cell is reported as a one-cycle pulse that names its pair. The block keeps a backlog count for every pair.

Time is cut into frames of a programmable length, counted in external cell slots. The fabric runs at twice the line rate, so each external slot holds two matching phases, and one clock cycle is one phase. At the first phase of a frame, every pair moves the smaller of its backlog and its reservation into a guaranteed count. In every phase a greedy maximal matcher serves the guaranteed counts and issues one crossbar configuration. Inputs are taken in a fixed priority order, and each input is given the lowest-numbered free output it is eligible for.

If a new batch is released while guaranteed cells from earlier frames are still waiting, an overrun flag is raised and those cells are kept. No pair is granted more cells in one frame than its reservation.

Top module: `rbm_sched`

## Requirements
- R1: While rst_ni is low, grant_o, frame_start_o, slot_phase_o and overrun_o are all zero, and every reservation, backlog, guaranteed count and per-frame grant count is cleared.
- R2: A reservation write (cfg_we_i with pair cfg_in_i, cfg_out_i) takes effect only while enable_i is low. While enable_i is high the write is ignored.
- R3: Once enabled, the phase counter runs from 0 to 2*frame_len_i-1 and wraps. A frame starts at phase 0, so the first frame starts in the first enabled cycle. All outputs are registered and appear one cycle after the cycle they describe. slot_phase_o is bit 0 of the phase counter, and frame_start_o marks phase 0.
- R4: At a frame start each pair moves min(backlog, reservation) cells from its backlog into its guaranteed count. An arrival pulse adds one to its pair's backlog in the same cycle, but it is not part of that cycle's move. Both counts saturate at their maximum.
- R5: Inputs are visited in order from 0 to N-1. Each input is granted the lowest-numbered output that is eligible for it and not already granted to an earlier input. grant_o bit i*N+j means input i is connected to output j.
- R6: In any cycle each input and each output appears in at most one grant.
- R7: A pair is eligible only when its guaranteed count is nonzero. Each grant takes one from that count.
- R8: Counting from one frame start up to the cycle before the next, a pair receives at most its reservation in grants. In a frame-start cycle the pair is eligible only if its reservation is nonzero.
- R9: overrun_o is raised in a frame-start cycle in which some guaranteed count would still be nonzero after that cycle's grant. The leftover cells are kept.
- R10: While enable_i is low, no grant is issued, no frame starts and no batch is released. Arrivals are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one matching phase per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the scheduler; low allows reservation writes |
| frame_len_i | input | FRAME_W | Frame length in external cell slots |
| cfg_we_i | input | 1 | Reservation write strobe |
| cfg_in_i | input | IDX_W | Input index of the reservation written |
| cfg_out_i | input | IDX_W | Output index of the reservation written |
| cfg_rate_i | input | RATE_W | Reservation in cells per frame |
| arr_valid_i | input | 1 | One cell arrived for the pair below |
| arr_in_i | input | IDX_W | Input index of the arrival |
| arr_out_i | input | IDX_W | Output index of the arrival |
| grant_o | output | N*N | Crossbar configuration, bit i*N+j |
| frame_start_o | output | 1 | The reported phase is the first of a frame |
| slot_phase_o | output | 1 | Which of the two phases of an external slot |
| overrun_o | output | 1 | A batch was released over unserved cells |

## Verification
The risky cycle is the frame start. In that one cycle the batch release, the matcher's grant and the reset of the per-frame grant counts all act on the same pair. The overrun test also depends on the grant issued in that same cycle.

The bench provokes this case with one-slot frames, where every second cycle releases a batch. Three inputs share output 0, so more guaranteed cells arrive than can drain, and cells are left over at most frame starts. A cycle-accurate reference model in the bench predicts each grant vector and overrun bit. The monitor compares these against the design and also audits per-frame grant counts against the reservations.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int unsigned DEF_N       = 4;
  localparam int unsigned DEF_RATE_W  = 4;
  localparam int unsigned DEF_BL_W    = 8;
  localparam int unsigned DEF_GQ_W    = 8;
  localparam int unsigned DEF_FRAME_W = 8;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } slot_phase_e;
endpackage

// File: rtl/rbm_frame_timer.sv
module rbm_frame_timer #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FRAME_W-1:0] len_i,
  output logic               frame_start_o,
  output rbm_pkg::slot_phase_e phase_o
);
  localparam int unsigned CW = FRAME_W + 1;

  logic [CW-1:0] cnt_q, cnt_inc, span;

  assign span    = {len_i, 1'b0};
  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_inc >= span) cnt_q <= '0;
    else                      cnt_q <= cnt_inc;
  end

  assign frame_start_o = en_i && (cnt_q == '0);
  assign phase_o       = rbm_pkg::slot_phase_e'(cnt_q[0]);
endmodule

// File: rtl/rbm_pair_cell.sv
module rbm_pair_cell #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned BL_W   = 8,
  parameter int unsigned GQ_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              release_i,
  input  logic              cfg_we_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              arr_i,
  input  logic              grant_i,
  output logic              elig_o,
  output logic              left_o
);
  logic [RATE_W-1:0] rate_q, srv_q, move;
  logic [BL_W-1:0]   bl_q;
  logic [GQ_W-1:0]   gq_q;
  logic [BL_W:0]     bl_sum;
  logic [GQ_W:0]     gq_sum;

  always_comb begin
    move = '0;
    if (release_i) move = (bl_q < BL_W'(rate_q)) ? RATE_W'(bl_q) : rate_q;
    bl_sum = {1'b0, bl_q} - (BL_W+1)'(move) + (BL_W+1)'(arr_i);
    gq_sum = {1'b0, gq_q} - (GQ_W+1)'(grant_i) + (GQ_W+1)'(move);
    // frame-start cycle opens a fresh per-frame budget
    elig_o = en_i && (gq_q != '0) &&
             (release_i ? (rate_q != '0) : (srv_q < rate_q));
    left_o = (gq_q - GQ_W'(grant_i)) != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      srv_q  <= '0;
      bl_q   <= '0;
      gq_q   <= '0;
    end else begin
      if (cfg_we_i) rate_q <= cfg_rate_i;
      bl_q  <= bl_sum[BL_W] ? '1 : bl_sum[BL_W-1:0];
      gq_q  <= gq_sum[GQ_W] ? '1 : gq_sum[GQ_W-1:0];
      srv_q <= release_i ? RATE_W'(grant_i) : srv_q + RATE_W'(grant_i);
    end
  end
endmodule

// File: rtl/rbm_greedy_matcher.sv
module rbm_greedy_matcher #(
  parameter int unsigned N = 4
) (
  input  logic [N*N-1:0] elig_i,
  output logic [N*N-1:0] grant_o
);
  logic [N-1:0] taken;
  logic         row_done;

  always_comb begin
    taken    = '0;
    grant_o  = '0;
    row_done = 1'b0;
    for (int i = 0; i < N; i++) begin
      row_done = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (!row_done && elig_i[i*N+j] && !taken[j]) begin
          grant_o[i*N+j] = 1'b1;
          taken[j]       = 1'b1;
          row_done       = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rbm_sched.sv
module rbm_sched #(
  parameter int unsigned N       = rbm_pkg::DEF_N,
  parameter int unsigned RATE_W  = rbm_pkg::DEF_RATE_W,
  parameter int unsigned BL_W    = rbm_pkg::DEF_BL_W,
  parameter int unsigned GQ_W    = rbm_pkg::DEF_GQ_W,
  parameter int unsigned FRAME_W = rbm_pkg::DEF_FRAME_W,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned NN     = N * N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [FRAME_W-1:0] frame_len_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_in_i,
  input  logic [IDX_W-1:0]   cfg_out_i,
  input  logic [RATE_W-1:0]  cfg_rate_i,
  input  logic               arr_valid_i,
  input  logic [IDX_W-1:0]   arr_in_i,
  input  logic [IDX_W-1:0]   arr_out_i,
  output logic [NN-1:0]      grant_o,
  output logic               frame_start_o,
  output logic               slot_phase_o,
  output logic               overrun_o
);
  logic                 fs;
  rbm_pkg::slot_phase_e ph;
  logic [NN-1:0]        elig, grant, left;
  logic                 cfg_ok;

  assign cfg_ok = cfg_we_i && !enable_i;

  rbm_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (enable_i),
    .len_i        (frame_len_i),
    .frame_start_o(fs),
    .phase_o      (ph)
  );

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar j = 0; j < N; j++) begin : g_out
      logic hit_cfg, hit_arr;
      assign hit_cfg = cfg_ok && (cfg_in_i == IDX_W'(i)) && (cfg_out_i == IDX_W'(j));
      assign hit_arr = arr_valid_i && (arr_in_i == IDX_W'(i)) && (arr_out_i == IDX_W'(j));

      rbm_pair_cell #(.RATE_W(RATE_W), .BL_W(BL_W), .GQ_W(GQ_W)) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (enable_i),
        .release_i (fs),
        .cfg_we_i  (hit_cfg),
        .cfg_rate_i(cfg_rate_i),
        .arr_i     (hit_arr),
        .grant_i   (grant[i*N+j]),
        .elig_o    (elig[i*N+j]),
        .left_o    (left[i*N+j])
      );
    end
  end

  rbm_greedy_matcher #(.N(N)) u_match (
    .elig_i (elig),
    .grant_o(grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o       <= '0;
      frame_start_o <= 1'b0;
      slot_phase_o  <= 1'b0;
      overrun_o     <= 1'b0;
    end else begin
      grant_o       <= grant;
      frame_start_o <= fs;
      slot_phase_o  <= (ph == rbm_pkg::PH_SECOND);
      overrun_o     <= fs && (|left);
    end
  end
endmodule

// File: rtl/rbm_sched_chk.sv
module rbm_sched_chk #(
  parameter int unsigned N       = 4,
  parameter int unsigned FRAME_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic [FRAME_W-1:0] frame_len_i,
  input logic [N*N-1:0]     grant_o,
  input logic               frame_start_o,
  input logic               slot_phase_o,
  input logic               overrun_o
);
  logic multi_hit;

  always_comb begin
    multi_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if ($countones(grant_o[i*N +: N]) > 1) multi_hit = 1'b1;
    end
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] col;
      for (int i = 0; i < N; i++) col[i] = grant_o[i*N+j];
      if (!$onehot0(col)) multi_hit = 1'b1;
    end
  end

  // R1
  always_comb begin
    if (rst_ni === 1'b0) begin
      reset_quiet_chk: assert (grant_o == '0 && !frame_start_o && !slot_phase_o && !overrun_o);
    end
  end

  // R6
  single_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !multi_hit);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (grant_o == '0 && !frame_start_o && !overrun_o));

  // R3
  first_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_i) |=> frame_start_o);

  // R3
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && enable_i && frame_len_i != '0) |=> !frame_start_o);

  // R9
  overrun_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> frame_start_o);
endmodule

bind rbm_sched rbm_sched_chk #(.N(N), .FRAME_W(FRAME_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .frame_len_i  (frame_len_i),
  .grant_o      (grant_o),
  .frame_start_o(frame_start_o),
  .slot_phase_o (slot_phase_o),
  .overrun_o    (overrun_o)
);

// File: tb/tb_rbm_sched.sv
module tb_rbm_sched;
  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int NN = N * N;
  localparam int FW = 8;

  typedef struct packed {
    logic [NN-1:0] g;
    logic          fs;
    logic          ov;
    logic          ph;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0;
  logic [FW-1:0] frame_len_i = 8'd3;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_in_i = '0, cfg_out_i = '0;
  logic [3:0]    cfg_rate_i = '0;
  logic          arr_valid_i = 1'b0;
  logic [1:0]    arr_in_i = '0, arr_out_i = '0;
  logic [NN-1:0] grant_o;
  logic          frame_start_o, slot_phase_o, overrun_o;

  int total = 0, bad = 0, ov_seen = 0;
  exp_t q[$];
  int rm[N][N], bl[N][N], gq[N][N], srv[N][N], per_frame[N][N];
  int m_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  rbm_sched dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // reference model of one cycle; pushes the outputs expected after the next edge
  task automatic model(input bit en, input int len, input bit we, input int ci, input int co,
                       input int rt, input bit av, input int ai, input int ao);
    exp_t e;
    bit fs, ov, el, rowd;
    bit [N-1:0] taken;
    int mv, g;
    fs = en && (m_cnt == 0);
    taken = '0;
    e = '0;
    for (int i = 0; i < N; i++) begin
      rowd = 0;
      for (int j = 0; j < N; j++) begin
        el = en && gq[i][j] != 0 && (fs ? rm[i][j] != 0 : srv[i][j] < rm[i][j]);
        if (el && !taken[j] && !rowd) begin
          e.g[i*N+j] = 1'b1; taken[j] = 1'b1; rowd = 1;
        end
      end
    end
    ov = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (fs && (gq[i][j] - int'(e.g[i*N+j])) != 0) ov = 1;
    e.fs = fs; e.ov = ov; e.ph = m_cnt[0];
    q.push_back(e);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        g  = int'(e.g[i*N+j]);
        mv = fs ? ((bl[i][j] < rm[i][j]) ? bl[i][j] : rm[i][j]) : 0;
        bl[i][j] = bl[i][j] - mv + ((av && ai == i && ao == j) ? 1 : 0);
        if (bl[i][j] > 255) bl[i][j] = 255;
        gq[i][j] = gq[i][j] - g + mv;
        if (gq[i][j] > 255) gq[i][j] = 255;
        srv[i][j] = fs ? g : srv[i][j] + g;
      end
    if (we && !en) rm[ci][co] = rt;
    m_cnt = en ? ((m_cnt + 1 >= 2 * len) ? 0 : m_cnt + 1) : 0;
  endtask

  task automatic cyc(input bit en, input int len, input bit we, input int ci, input int co,
                     input int rt, input bit av, input int ai, input int ao);
    @(negedge clk_i);
    enable_i = en; frame_len_i = FW'(len);
    cfg_we_i = we; cfg_in_i = 2'(ci); cfg_out_i = 2'(co); cfg_rate_i = 4'(rt);
    arr_valid_i = av; arr_in_i = 2'(ai); arr_out_i = 2'(ao);
    model(en, len, we, ci, co, rt, av, ai, ao);
  endtask

  function automatic void lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(grant_o == e.g, "R2 R4 R5 R7 R10 grant", int'(grant_o), int'(e.g));
      chk(frame_start_o == e.fs, "R3 frame_start", int'(frame_start_o), int'(e.fs));
      chk(slot_phase_o == e.ph, "R3 slot_phase", int'(slot_phase_o), int'(e.ph));
      chk(overrun_o == e.ov, "R9 overrun", int'(overrun_o), int'(e.ov));
      if (overrun_o) ov_seen++;
      for (int i = 0; i < N; i++)
        chk($countones(grant_o[i*N +: N]) <= 1, "R6 row", int'(grant_o), i);
      if (frame_start_o) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            chk(per_frame[i][j] <= rm[i][j], "R8 per-frame cap", per_frame[i][j], rm[i][j]);
            per_frame[i][j] = 0;
          end
      end
      for (int k = 0; k < NN; k++) per_frame[k/N][k%N] += int'(grant_o[k]);
    end
  end

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rm[i][j] = 0; bl[i][j] = 0; gq[i][j] = 0; srv[i][j] = 0; per_frame[i][j] = 0;
      end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(grant_o == '0 && !frame_start_o && !slot_phase_o && !overrun_o, "R1 reset outputs",
        int'({grant_o, frame_start_o, slot_phase_o, overrun_o}), 0);
    rst_ni = 1'b1;

    // reservations, written while disabled
    cyc(0, 3, 1, 0, 0, 2, 0, 0, 0);
    cyc(0, 3, 1, 0, 1, 1, 0, 0, 0);
    cyc(0, 3, 1, 1, 0, 2, 0, 0, 0);
    cyc(0, 3, 1, 2, 2, 3, 0, 0, 0);
    cyc(0, 3, 1, 3, 2, 1, 0, 0, 0);
    cyc(0, 3, 1, 3, 3, 1, 0, 0, 0);
    // backlog while disabled (R10: no grants)
    for (int k = 0; k < 24; k++) begin
      lfsr_step();
      cyc(0, 3, 0, 0, 0, 0, 1, int'(lfsr[1:0]), int'(lfsr[3:2]));
    end
    // enabled run; writes to pair 1,1 must be ignored (R2)
    for (int k = 0; k < 80; k++) begin
      lfsr_step();
      cyc(1, 3, (k % 7) == 0, 1, 1, 5, lfsr[4], int'(lfsr[1:0]), int'(lfsr[3:2]));
    end
    // overload output 0 with one-slot frames (R9)
    cyc(0, 1, 1, 0, 0, 3, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 3, 0, 0, 0);
    cyc(0, 1, 1, 2, 0, 3, 0, 0, 0);
    for (int k = 0; k < 36; k++) cyc(0, 1, 0, 0, 0, 0, 1, k % 3, 0);
    for (int k = 0; k < 40; k++) begin
      lfsr_step();
      cyc(1, 1, 0, 0, 0, 0, lfsr[5], int'(lfsr[1:0]), 0);
    end
    // disable again and let leftovers sit (R10)
    for (int k = 0; k < 6; k++) cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    chk(ov_seen > 0, "R9 overrun observed", ov_seen, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule